// File: doc/BRIEF.md
# Serial SAR converter read controller

This block is the host-side master for a 16-bit successive-approximation converter that has a three-wire serial port. It runs from a fast system clock. A conversion starts when chip select is driven low. The block then generates a data clock by dividing the system clock, and passes the serial data line through a synchronizer. Each bit is sampled on a rising data-clock edge, because the converter changes its output on falling edges. The first edges give the converter time to sample its input, so the controller ignores them. It then checks that the next bit is the low null bit. After that it shifts in the result, most significant bit first.

A caller can keep fewer than 16 bits to end a conversion early. The unreceived low bits are then reported as zero. A caller can also ask for the least-significant-bit-first replay that the converter sends after the forward word. The controller rebuilds that replay and compares it with the forward word. At the end of a conversion, chip select goes high and the block presents a registered 16-bit word with a one-cycle strobe and two error flags. Chip select then stays high for a parameterised number of idle cycles before the block accepts the next request.

Top module: `adcrd_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, chip select is high, the data clock is low, the strobe is low, and the result word and both error flags are zero.
- R2: While chip select is low, every high phase and every low phase of the data clock lasts exactly HALF_DIV system cycles. The clock starts low when chip select falls. The data clock is low whenever chip select is high.
- R3: A conversion starts, with chip select going low, only while `start` is high and the block is idle. When `start` is held, chip select stays high for exactly IDLE_CYC+1 system cycles between the end of one conversion and the start of the next.
- R4: The bit sampled on rising edge 6 (counted from chip select low) is the null bit. The null error flag of that conversion is 1 exactly when this bit is high.
- R5: Rising edges 7 through 22 capture data bits 15 down to 0, most significant first. The result is plain unsigned binary.
- R6: A kept-bit count n from 1 to 15 ends the conversion after rising edge 6+n. The result then holds the n received bits in its top n positions and zeros below. A count of 0, or any count above 16, means 16.
- R7: When replay is enabled and all 16 bits are kept, the conversion runs to rising edge 37. Edges 23 to 37 carry bits 1 to 15, least significant first, and bit 0 is shared with the forward word. The replay error flag is 1 exactly when the rebuilt word differs from the forward word. When fewer than 16 bits are kept, replay is ignored: no extra edges are generated and the flag stays 0.
- R8: The strobe is a one-cycle pulse in the cycle where chip select rises. The result and both flags stay unchanged until the next strobe.
- R9: The kept-bit count and the replay enable are latched when chip select falls. Changing them during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, level sensitive |
| cfg_nbits | input | NBW (5) | Number of bits to keep; 0 or above DW means DW |
| cfg_replay | input | 1 | Also read and compare the LSB-first replay |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Data clock to the converter |
| result_valid | output | 1 | One-cycle strobe: a new result is present |
| result | output | DW (16) | Converted word, with unreceived bits zero |
| null_err | output | 1 | The null bit was sampled high |
| replay_err | output | 1 | The replayed word differed from the forward word |

## Verification
The null-bit check and the replay comparison are separate functions, but both verdicts are registered in the same end-of-conversion cycle. The converter model can drive the null bit high and flip one replayed bit within a single conversion. In that case both flags must rise together on the same strobe, and the result word must still be correct. The model also flips each replay bit position in turn with a valid null bit, and drives a bad null bit with replay off, so that each flag is shown to respond on its own. Every conversion is also checked for its number of rising edges, the lengths of its clock phases, and the chip-select gap before it.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  // Controller phase: idle with chip select high, clocking bits, or
  // waiting for the falling edge that follows the last sampled bit.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LAST = 2'd2
  } adcrd_state_e;

endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
  parameter int HALF_DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int DCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DCW-1:0] div_q, div_d;
  logic           sclk_q, sclk_d;
  logic           term;

  always_comb begin
    term     = run && (div_q == DCW'(HALF_DIV - 1));
    rise_evt = term && !sclk_q;
    fall_evt = term && sclk_q;
    div_d    = div_q;
    sclk_d   = sclk_q;
    if (!run) begin
      div_d  = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      div_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      div_d  = div_q + DCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  // R2: a clock phase holds until the divider reaches its terminal count
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !term) |=> $stable(sclk_q));

  // R2: clock is parked low whenever the generator is stopped
  a_r2_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
  parameter int DW        = 16,
  parameter int NULL_EDGE = 6,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rise_evt,
  input  logic          din,
  input  logic [CW-1:0] last_edge,
  output logic          hit_last,
  output logic          null_bit,
  output logic [DW-1:0] fwd_word,
  output logic [DW-1:0] rep_word
);

  localparam int FWD_FIRST = NULL_EDGE + 1;
  localparam int FWD_LAST  = NULL_EDGE + DW;
  localparam int REP_LAST  = FWD_LAST + DW - 1;

  logic [CW-1:0] edge_q, edge_d, edge_inc;
  logic          null_q, null_d;
  logic [DW-1:0] fwd_q, fwd_d;
  logic [DW-2:0] rep_q, rep_d;

  always_comb begin
    edge_inc = edge_q + CW'(1);
    edge_d   = edge_q;
    null_d   = null_q;
    fwd_d    = fwd_q;
    rep_d    = rep_q;
    if (clear) begin
      edge_d = '0;
      null_d = 1'b0;
      fwd_d  = '0;
      rep_d  = '0;
    end else if (rise_evt) begin
      edge_d = edge_inc;
      if (edge_inc == CW'(NULL_EDGE))
        null_d = din;
      if ((edge_inc >= CW'(FWD_FIRST)) && (edge_inc <= CW'(FWD_LAST)))
        fwd_d = {fwd_q[DW-2:0], din};
      if ((edge_inc > CW'(FWD_LAST)) && (edge_inc <= CW'(REP_LAST)))
        rep_d = {din, rep_q[DW-2:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      null_q <= 1'b0;
      fwd_q  <= '0;
      rep_q  <= '0;
    end else begin
      edge_q <= edge_d;
      null_q <= null_d;
      fwd_q  <= fwd_d;
      rep_q  <= rep_d;
    end
  end

  assign hit_last = rise_evt && !clear && (edge_inc == last_edge);
  assign null_bit = null_q;
  assign fwd_word = fwd_q;
  assign rep_word = {rep_q, fwd_q[0]};

  // R7: the edge counter never runs past the end of the replay phase
  a_r7_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= CW'(REP_LAST));

  // R9: a clear always returns the edge count to zero
  a_r9_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (edge_q == '0));

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DW          = 16,
  parameter int HALF_DIV    = 27,
  parameter int IDLE_CYC    = 5,
  parameter int NULL_EDGE   = 6,
  parameter int SYNC_STAGES = 2,
  localparam int NBW        = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NBW-1:0] cfg_nbits,
  input  logic           cfg_replay,
  input  logic           adc_sdo,
  output logic           adc_cs_n,
  output logic           adc_sclk,
  output logic           result_valid,
  output logic [DW-1:0]  result,
  output logic           null_err,
  output logic           replay_err
);

  localparam int REP_LAST = NULL_EDGE + 2 * DW - 1;
  localparam int CW       = $clog2(REP_LAST + 1);
  localparam int ICW      = (IDLE_CYC > 0) ? $clog2(IDLE_CYC + 1) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sq;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i_n = rst_sq[1];

  // datapath instances
  logic          sdo_s;
  logic          run, rise_evt, fall_evt;
  logic          clear, hit_last, null_bit;
  logic [DW-1:0] fwd_word, rep_word;
  logic [CW-1:0] last_edge;

  adcrd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (adc_sdo),
    .q     (sdo_s)
  );

  adcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run),
    .sclk     (adc_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  adcrd_capture #(.DW(DW), .NULL_EDGE(NULL_EDGE), .CW(CW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (clear),
    .rise_evt  (rise_evt),
    .din       (sdo_s),
    .last_edge (last_edge),
    .hit_last  (hit_last),
    .null_bit  (null_bit),
    .fwd_word  (fwd_word),
    .rep_word  (rep_word)
  );

  // control state
  adcrd_state_e   state_q, state_d;
  logic [NBW-1:0] nb_q, nb_d, eff_nb;
  logic           rpl_q, rpl_d;
  logic           cs_n_q, cs_n_d;
  logic [ICW-1:0] idle_q, idle_d;
  logic           valid_q, valid_d;
  logic [DW-1:0]  res_q, res_d;
  logic           nerr_q, nerr_d;
  logic           rerr_q, rerr_d;

  always_comb begin
    if ((cfg_nbits == '0) || (cfg_nbits > NBW'(DW))) eff_nb = NBW'(DW);
    else                                             eff_nb = cfg_nbits;
  end

  assign run       = (state_q != ST_IDLE);
  assign last_edge = rpl_q ? CW'(REP_LAST) : (CW'(NULL_EDGE) + CW'(nb_q));

  always_comb begin
    state_d = state_q;
    nb_d    = nb_q;
    rpl_d   = rpl_q;
    cs_n_d  = cs_n_q;
    idle_d  = idle_q;
    valid_d = 1'b0;
    res_d   = res_q;
    nerr_d  = nerr_q;
    rerr_d  = rerr_q;
    clear   = 1'b0;
    if (idle_q != '0) idle_d = idle_q - ICW'(1);
    unique case (state_q)
      ST_IDLE: begin
        if (start && (idle_q == '0)) begin
          state_d = ST_RUN;
          cs_n_d  = 1'b0;
          nb_d    = eff_nb;
          rpl_d   = cfg_replay && (eff_nb == NBW'(DW));
          clear   = 1'b1;
        end
      end
      ST_RUN: begin
        if (hit_last) state_d = ST_LAST;
      end
      ST_LAST: begin
        if (fall_evt) begin
          state_d = ST_IDLE;
          cs_n_d  = 1'b1;
          valid_d = 1'b1;
          idle_d  = ICW'(IDLE_CYC);
          res_d   = fwd_word << (NBW'(DW) - nb_q);
          nerr_d  = null_bit;
          rerr_d  = rpl_q && (rep_word != fwd_word);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      nb_q    <= NBW'(DW);
      rpl_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      idle_q  <= '0;
      valid_q <= 1'b0;
      res_q   <= '0;
      nerr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nb_q    <= nb_d;
      rpl_q   <= rpl_d;
      cs_n_q  <= cs_n_d;
      idle_q  <= idle_d;
      valid_q <= valid_d;
      res_q   <= res_d;
      nerr_q  <= nerr_d;
      rerr_q  <= rerr_d;
    end
  end

  assign adc_cs_n     = cs_n_q;
  assign result_valid = valid_q;
  assign result       = res_q;
  assign null_err     = nerr_q;
  assign replay_err   = rerr_q;

  // R2: no data clock activity while deselected
  a_r2_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    adc_cs_n |-> !adc_sclk);

  // R8: strobe coincides with the chip-select rise
  a_r8_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(adc_cs_n) |-> result_valid);

  // R8: strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    result_valid |=> !result_valid);

  // R3: a new conversion only begins once the idle gap has run out
  a_r3_gap_done: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(adc_cs_n) |-> ($past(idle_q) == '0));

  // R9: latched configuration is frozen while clocking bits
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_IDLE) |=> ($stable(nb_q) && $stable(rpl_q)));

endmodule

// File: tb/test_adcrd_ctrl.sv
module test_adcrd_ctrl;

  localparam int DW    = 16;
  localparam int HALF  = 4;
  localparam int IDLE  = 5;
  localparam int NBW   = 5;
  localparam int WDOG  = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [NBW-1:0] cfg_nbits = '0;
  logic           cfg_replay = 1'b0;
  logic           adc_sdo;
  logic           adc_cs_n, adc_sclk, result_valid, null_err, replay_err;
  logic [DW-1:0]  result;

  always #4 clk = ~clk;   // 125 MHz

  adcrd_ctrl #(.DW(DW), .HALF_DIV(HALF), .IDLE_CYC(IDLE)) i_adcrd_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_nbits    (cfg_nbits),
    .cfg_replay   (cfg_replay),
    .adc_sdo      (adc_sdo),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .result_valid (result_valid),
    .result       (result),
    .null_err     (null_err),
    .replay_err   (replay_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // converter model: data changes on falling clock edges
  logic [15:0] m_code = '0;
  bit          m_badnull = 1'b0;
  int          m_flip = 0;
  int          m_fcnt = 0;
  bit          m_armed = 1'b1;
  logic        m_sdo = 1'b1;
  assign adc_sdo = m_sdo;

  always @(negedge adc_sclk or posedge adc_cs_n or negedge adc_cs_n) begin
    if (adc_cs_n) begin
      m_armed = 1'b1;
      m_fcnt  = 0;
      m_sdo   = 1'b1;
    end else if (m_armed) begin
      m_armed = 1'b0;
      m_fcnt  = 0;
      m_sdo   = 1'b1;
    end else begin
      m_fcnt++;
      if (m_fcnt == 5)
        m_sdo = m_badnull;
      else if (m_fcnt >= 6 && m_fcnt <= 21)
        m_sdo = m_code[21 - m_fcnt];
      else if (m_fcnt >= 22 && m_fcnt <= 36)
        m_sdo = m_code[m_fcnt - 21] ^ ((m_fcnt - 21) == m_flip);
      else
        m_sdo = 1'b1;
    end
  end

  // rising edge counter per conversion
  int rise_cnt = 0;
  always @(posedge adc_sclk) if (!adc_cs_n) rise_cnt++;

  // phase length and chip-select gap monitor
  bit   in_conv = 1'b0;
  logic seg_lvl = 1'b0;
  int   seg_len = 0;
  int   gap = 0;
  bit   gap_armed = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_cs_n) begin
        if (!in_conv) begin
          in_conv = 1'b1;
          chk(adc_sclk == 1'b0, "R2 clock starts low", adc_sclk, 0);
          if (gap_armed) chk(gap == IDLE + 1, "R3 cs high gap", gap, IDLE + 1);
          seg_lvl = adc_sclk;
          seg_len = 1;
        end else if (adc_sclk == seg_lvl) begin
          seg_len++;
        end else begin
          chk(seg_len == HALF, "R2 clock phase length", seg_len, HALF);
          seg_lvl = adc_sclk;
          seg_len = 1;
        end
      end else begin
        if (in_conv) begin
          in_conv = 1'b0;
          chk(seg_len == HALF, "R2 last phase length", seg_len, HALF);
          gap = 0;
        end
        gap++;
        if (adc_sclk) chk(1'b0, "R2 clock high while deselected", 1, 0);
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input int k);
    return 16'((k * 40503 + 12345) ^ (k << 9));
  endfunction

  task automatic run_conv(input logic [15:0] code, input int nb, input bit rep,
                          input bit badnull, input int flip, input bit chg);
    int eff, exp_rises;
    logic [15:0] exp_res, mask;
    bit exp_rerr;
    int t;
    eff       = (nb == 0 || nb > 16) ? 16 : nb;
    mask      = 16'hFFFF << (16 - eff);
    exp_res   = code & mask;
    exp_rises = (rep && eff == 16) ? 37 : 6 + eff;
    exp_rerr  = rep && (eff == 16) && (flip != 0);
    m_code    = code;
    m_badnull = badnull;
    m_flip    = flip;
    @(negedge clk);
    cfg_nbits  = NBW'(nb);
    cfg_replay = rep;
    start      = 1'b1;
    rise_cnt   = 0;
    t = 0;
    while (adc_cs_n && t < 100) begin @(negedge clk); t++; end
    start = 1'b0;
    if (chg) begin
      // R9: reconfigure mid-conversion; must not matter
      cfg_nbits  = NBW'(16);
      cfg_replay = 1'b1;
    end
    t = 0;
    while (!result_valid && t < 2000) begin @(negedge clk); t++; end
    chk(result_valid, "R8 strobe seen", result_valid, 1);
    chk(adc_cs_n, "R8 cs high at strobe", adc_cs_n, 1);
    chk(result == exp_res, (eff < 16) ? "R6 short result" : "R5 result", result, exp_res);
    chk(rise_cnt == exp_rises, rep ? "R7 edge count" : "R6 edge count", rise_cnt, exp_rises);
    chk(null_err == badnull, "R4 null flag", null_err, badnull);
    chk(replay_err == exp_rerr, "R7 replay flag", replay_err, exp_rerr);
    @(negedge clk);
    chk(!result_valid, "R8 strobe one cycle", result_valid, 0);
    chk(result == exp_res, "R8 result held", result, exp_res);
    gap_armed = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs in reset", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk in reset", adc_sclk, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs after reset", adc_cs_n, 1);
    chk(result_valid == 1'b0, "R1 strobe after reset", result_valid, 0);
    chk(result == '0, "R1 result after reset", result, 0);
    chk(!null_err && !replay_err, "R1 flags after reset", {null_err, replay_err}, 0);

    // R5 R6: every kept-bit count, including 0 and counts above 16
    for (int nb = 0; nb <= 20; nb++) run_conv(mk(nb), nb, 1'b0, 1'b0, 0, 1'b0);
    // R5 R7: walking ones with replay, plus extremes
    for (int k = 0; k < 16; k++) run_conv(16'h0001 << k, 16, 1'b1, 1'b0, 0, 1'b0);
    run_conv(16'hFFFF, 16, 1'b1, 1'b0, 0, 1'b0);
    run_conv(16'h0000, 16, 1'b1, 1'b0, 0, 1'b0);
    // R7: a corrupted replay bit at each position
    for (int j = 1; j < 16; j++) run_conv(mk(j + 40), 16, 1'b1, 1'b0, j, 1'b0);
    // R7: replay ignored when short cycling
    run_conv(mk(3), 8, 1'b1, 1'b0, 5, 1'b0);
    // R4: high null bit
    run_conv(mk(7), 16, 1'b0, 1'b1, 0, 1'b0);
    run_conv(mk(8), 5, 1'b0, 1'b1, 0, 1'b0);
    // R4 R7: both faults in one conversion
    run_conv(mk(9), 16, 1'b1, 1'b1, 3, 1'b0);
    // R9: config change during conversion
    run_conv(mk(10), 4, 1'b0, 1'b0, 0, 1'b1);
    // R8: flags return to zero on the next clean conversion
    run_conv(mk(11), 16, 1'b1, 1'b0, 0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule